// File: doc/BRIEF.md
# Transactional Read/Write Set Signature Unit

This block records the memory footprint of one hardware thread's running transaction. It keeps two Bloom-filter signatures, one for the read set and one for the write set. Each signature is split into independent banks, and each bank has its own low-cost hash. The hash XORs a block-index field of the physical address with a rotated page-number field. Only transactional references to pages that address translation marks as shared are recorded. References to private pages never set a bit, so they cannot cause spurious conflicts.

Remote coherence probes are tested against both signatures, and any hit is reported as a typed conflict flag. A second pair of signatures holds the union of the saved signatures of descheduled threads. System software loads this pair word by word through a dedicated write port. Every local access is tested against it. A clear pulse empties the local signatures when the transaction commits or aborts.

Top module: `txsig_top`

## Requirements
- R1: After synchronous reset, all four signatures (local read, local write, summary read, summary write) are empty and every conflict output is 0.
- R2: Bank j (j = 0, 1) is indexed by addr[15:6] XOR (addr[25:16] rotated left by 3*j positions within 10 bits). Bits [5:0] and [31:26] of the address play no part in any index.
- R3: An address reports membership only when its bit is set in every bank. An inserted address never misses until the next clear. Different addresses with equal indices in all banks (for example, addresses that differ only in bits [31:26]) also report a hit.
- R4: With prb_valid=1, a probe read (prb_write=0) that hits the local write set raises cfl_wr. A probe write (prb_write=1) that hits the read set raises cfl_rw, and one that hits the write set raises cfl_ww. A probe read never raises cfl_rw or cfl_ww. With prb_valid=0, these three outputs are 0.
- R5: A local access with acc_valid=1, acc_tx=1 and acc_shared=1 is inserted into the read set when acc_store=0 and into the write set when acc_store=1. If acc_tx=0 or acc_shared=0, neither set is changed.
- R6: clear=1 empties both local signatures at the next clock edge. An insert requested in the same cycle is dropped and does not appear in the same-cycle query either. clear does not alter the summary signatures.
- R7: A probe in the same cycle as an insert sees the bits that the insert is setting, so an insert and a probe to the same address in one cycle report a hit.
- R8: When sum_we=1, word sum_waddr of the summary selected by sum_sel (0 for read, 1 for write) is replaced by sum_wdata. Bit i of word w is flat bit w*32+i, and flat bit f belongs to bank f/1024 at index f%1024. A query in the same cycle as a write sees the old contents.
- R9: cfl_sum=1 when acc_valid=1 and the access address hits the summary write set, or when it is a store (acc_store=1) that hits the summary read set. This holds whatever the values of acc_tx and acc_shared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Empty both local signatures (commit or abort) |
| acc_valid | input | 1 | Local memory access present |
| acc_store | input | 1 | Local access is a store |
| acc_tx | input | 1 | Local access is transactional |
| acc_shared | input | 1 | Page of the local access is marked shared |
| acc_addr | input | 32 | Physical address of the local access |
| prb_valid | input | 1 | Remote coherence probe present |
| prb_write | input | 1 | Remote probe requests write permission |
| prb_addr | input | 32 | Physical address of the remote probe |
| sum_we | input | 1 | Summary word write enable |
| sum_sel | input | 1 | Summary target: 0 read set, 1 write set |
| sum_waddr | input | 6 | Summary word index |
| sum_wdata | input | 32 | Summary word data |
| cfl_wr | output | 1 | Remote read hit the local write set |
| cfl_rw | output | 1 | Remote write hit the local read set |
| cfl_ww | output | 1 | Remote write hit the local write set |
| cfl_sum | output | 1 | Local access hit the descheduled-thread summary |

## Verification
The bench builds the block with its default geometry: 32-bit addresses, two banks of 1024 bits, fields at bits 6 and 16, a rotation step of 3 and 32-bit summary words. At these values the bench can compute exact bank indices for chosen addresses. It can therefore form deliberate aliases, such as addresses that differ only in the high bits, and set single summary bits word by word across all 64 words of each summary. A random phase draws addresses from a narrow field range so that hits, near-misses and same-cycle insert/probe collisions occur often alongside clears and summary writes.

// File: rtl/txsig_pkg.sv
package txsig_pkg;

    typedef enum logic [0:0] {
        SET_RD = 1'b0,
        SET_WR = 1'b1
    } set_e;

    typedef struct packed {
        logic wr;
        logic rw;
        logic ww;
        logic sum;
    } cfl_t;

endpackage

// File: rtl/txsig_hash.sv
module txsig_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int LO_POS = 6,
    parameter int HI_POS = 16,
    parameter int ROT    = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int R = ROT % IDX_W;

    logic [IDX_W-1:0] hi_rot;
    logic             unused_addr;

    // rotate the page-side field left by R; pure wiring, no gates
    for (genvar i = 0; i < IDX_W; i++) begin : g_rot
        assign hi_rot[i] = addr[HI_POS + ((i + IDX_W - R) % IDX_W)];
    end

    assign idx         = addr[LO_POS +: IDX_W] ^ hi_rot;
    assign unused_addr = ^addr;

endmodule

// File: rtl/txsig_set.sv
module txsig_set #(
    parameter int NBANK = 2,
    parameter int IDX_W = 10
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr,
    input  logic                        ins_en,
    input  logic [NBANK-1:0][IDX_W-1:0] ins_idx,
    input  logic [NBANK-1:0][IDX_W-1:0] qry_idx,
    output logic                        hit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [NBANK-1:0][DEPTH-1:0] bits;
    logic [NBANK-1:0]            bank_hit;
    logic                        ins_go;

    assign ins_go = ins_en & ~clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits <= '0;
        end else if (ins_go) begin
            for (int b = 0; b < NBANK; b++) begin
                bits[b][ins_idx[b]] <= 1'b1;
            end
        end
    end

    // query sees stored bits plus the bits being written this cycle
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_hit[b] = bits[b][qry_idx[b]] |
                             (ins_go & (ins_idx[b] == qry_idx[b]));
    end

    assign hit = &bank_hit;

    // R3: without a clear no set bit is ever lost
    a_r3_bits_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((bits & $past(bits)) == $past(bits)));

endmodule

// File: rtl/txsig_summary.sv
module txsig_summary #(
    parameter int NBANK   = 2,
    parameter int IDX_W   = 10,
    parameter int WORD_W  = 32,
    parameter int WADDR_W = $clog2((NBANK << IDX_W) / WORD_W)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [WADDR_W-1:0]          waddr,
    input  logic [WORD_W-1:0]           wdata,
    input  logic [NBANK-1:0][IDX_W-1:0] qry_idx,
    output logic                        hit
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int FLAT  = NBANK * DEPTH;
    localparam int NWORD = FLAT / WORD_W;

    logic [NWORD-1:0][WORD_W-1:0] words;
    logic [FLAT-1:0]              flat;
    logic [NBANK-1:0]             bank_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign flat = words;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DEPTH-1:0] bank_v;
        assign bank_v      = flat[b*DEPTH +: DEPTH];
        assign bank_hit[b] = bank_v[qry_idx[b]];
    end

    assign hit = &bank_hit;

endmodule

// File: rtl/txsig_top.sv
module txsig_top
    import txsig_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 10,
    parameter int NBANK    = 2,
    parameter int LO_POS   = 6,
    parameter int HI_POS   = 16,
    parameter int ROT_STEP = 3,
    parameter int SUM_W    = 32,
    parameter int SUM_AW   = $clog2((NBANK << IDX_W) / SUM_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic              acc_tx,
    input  logic              acc_shared,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              prb_valid,
    input  logic              prb_write,
    input  logic [ADDR_W-1:0] prb_addr,
    input  logic              sum_we,
    input  logic              sum_sel,
    input  logic [SUM_AW-1:0] sum_waddr,
    input  logic [SUM_W-1:0]  sum_wdata,
    output logic              cfl_wr,
    output logic              cfl_rw,
    output logic              cfl_ww,
    output logic              cfl_sum
);
    logic [NBANK-1:0][IDX_W-1:0] acc_idx;
    logic [NBANK-1:0][IDX_W-1:0] prb_idx;
    logic ins_ok, ins_rd, ins_wr;
    logic rd_hit, wr_hit, srd_hit, swr_hit;
    logic srd_we, swr_we;
    cfl_t cfl;

    for (genvar b = 0; b < NBANK; b++) begin : g_hash
        txsig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO_POS(LO_POS),
                     .HI_POS(HI_POS), .ROT(b * ROT_STEP)) u_hacc (
            .addr(acc_addr), .idx(acc_idx[b]));
        txsig_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LO_POS(LO_POS),
                     .HI_POS(HI_POS), .ROT(b * ROT_STEP)) u_hprb (
            .addr(prb_addr), .idx(prb_idx[b]));
    end

    // private-page and non-transactional references stay out
    assign ins_ok = acc_valid & acc_tx & acc_shared;
    assign ins_rd = ins_ok & ~acc_store;
    assign ins_wr = ins_ok & acc_store;

    txsig_set #(.NBANK(NBANK), .IDX_W(IDX_W)) u_rdset (
        .clk(clk), .rst(rst), .clr(clear), .ins_en(ins_rd),
        .ins_idx(acc_idx), .qry_idx(prb_idx), .hit(rd_hit));

    txsig_set #(.NBANK(NBANK), .IDX_W(IDX_W)) u_wrset (
        .clk(clk), .rst(rst), .clr(clear), .ins_en(ins_wr),
        .ins_idx(acc_idx), .qry_idx(prb_idx), .hit(wr_hit));

    assign srd_we = sum_we & (set_e'(sum_sel) == SET_RD);
    assign swr_we = sum_we & (set_e'(sum_sel) == SET_WR);

    txsig_summary #(.NBANK(NBANK), .IDX_W(IDX_W), .WORD_W(SUM_W),
                    .WADDR_W(SUM_AW)) u_sumrd (
        .clk(clk), .rst(rst), .we(srd_we), .waddr(sum_waddr),
        .wdata(sum_wdata), .qry_idx(acc_idx), .hit(srd_hit));

    txsig_summary #(.NBANK(NBANK), .IDX_W(IDX_W), .WORD_W(SUM_W),
                    .WADDR_W(SUM_AW)) u_sumwr (
        .clk(clk), .rst(rst), .we(swr_we), .waddr(sum_waddr),
        .wdata(sum_wdata), .qry_idx(acc_idx), .hit(swr_hit));

    always_comb begin
        cfl.wr  = prb_valid & ~prb_write & wr_hit;
        cfl.rw  = prb_valid &  prb_write & rd_hit;
        cfl.ww  = prb_valid &  prb_write & wr_hit;
        cfl.sum = acc_valid & (swr_hit | (acc_store & srd_hit));
    end

    assign cfl_wr  = cfl.wr;
    assign cfl_rw  = cfl.rw;
    assign cfl_ww  = cfl.ww;
    assign cfl_sum = cfl.sum;

    // R4: no probe, no probe-type conflict
    a_r4_quiet_without_probe: assert property (@(posedge clk) disable iff (rst)
        !prb_valid |-> !(cfl_wr || cfl_rw || cfl_ww));

    // R4: a remote read only ever reports the WR kind
    a_r4_read_kind_only: assert property (@(posedge clk) disable iff (rst)
        (prb_valid && !prb_write) |-> !(cfl_rw || cfl_ww));

    // R7: same-cycle store insert and write probe to one address collide
    a_r7_insert_visible: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_tx && acc_shared && acc_store && !clear &&
         prb_valid && prb_write && prb_addr == acc_addr) |-> cfl_ww);

    // R3: a recorded store address is found on the following cycle
    a_r3_no_false_negative: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_tx && acc_shared && acc_store && !clear) |=>
        (!(prb_valid && !prb_write && prb_addr == $past(acc_addr)) || cfl_wr));

    // R6: right after a clear, only a same-cycle insert can produce a hit
    a_r6_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!(prb_valid && !prb_write &&
                     !(acc_valid && acc_tx && acc_shared && acc_store && !clear))
                   || !cfl_wr));

endmodule

// File: tb/test_txsig_top.sv
module test_txsig_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst, clear;
    logic        acc_valid, acc_store, acc_tx, acc_shared;
    logic [31:0] acc_addr;
    logic        prb_valid, prb_write;
    logic [31:0] prb_addr;
    logic        sum_we, sum_sel;
    logic [5:0]  sum_waddr;
    logic [31:0] sum_wdata;
    logic        cfl_wr, cfl_rw, cfl_ww, cfl_sum;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // behavioural model state
    bit m_rd  [2][1024];
    bit m_wr  [2][1024];
    bit m_srd [2048];
    bit m_swr [2048];

    always #(CLK_P/2) clk = ~clk;

    txsig_top i_txsig_top (
        .clk(clk), .rst(rst), .clear(clear),
        .acc_valid(acc_valid), .acc_store(acc_store), .acc_tx(acc_tx),
        .acc_shared(acc_shared), .acc_addr(acc_addr),
        .prb_valid(prb_valid), .prb_write(prb_write), .prb_addr(prb_addr),
        .sum_we(sum_we), .sum_sel(sum_sel), .sum_waddr(sum_waddr),
        .sum_wdata(sum_wdata),
        .cfl_wr(cfl_wr), .cfl_rw(cfl_rw), .cfl_ww(cfl_ww), .cfl_sum(cfl_sum));

    // R2 index formula
    function automatic int hidx(logic [31:0] a, int j);
        int lo, hi, r, rh;
        lo = int'((a >> 6) & 32'h3ff);
        hi = int'((a >> 16) & 32'h3ff);
        r  = (3 * j) % 10;
        rh = ((hi << r) | (hi >> (10 - r))) & 1023;
        return lo ^ rh;
    endfunction

    task automatic idle();
        clear = 0; acc_valid = 0; acc_store = 0; acc_tx = 0; acc_shared = 0;
        acc_addr = '0; prb_valid = 0; prb_write = 0; prb_addr = '0;
        sum_we = 0; sum_sel = 0; sum_waddr = '0; sum_wdata = '0;
    endtask

    task automatic chk(string tag, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // one clock: compare all outputs against the model, then advance the model
    task automatic step(string tag);
        bit ins, ins_r, ins_w, rh, wh, sh;
        int ai, pi;
        #2;
        ins   = acc_valid && acc_tx && acc_shared && !clear;
        ins_r = ins && !acc_store;
        ins_w = ins && acc_store;
        rh = 1; wh = 1;
        for (int j = 0; j < 2; j++) begin
            ai = hidx(acc_addr, j);
            pi = hidx(prb_addr, j);
            rh = rh && (m_rd[j][pi] || (ins_r && ai == pi));
            wh = wh && (m_wr[j][pi] || (ins_w && ai == pi));
        end
        sh = 1'b0;
        if (acc_valid) begin
            bit swh, srh;
            swh = 1; srh = 1;
            for (int j = 0; j < 2; j++) begin
                swh = swh && m_swr[j*1024 + hidx(acc_addr, j)];
                srh = srh && m_srd[j*1024 + hidx(acc_addr, j)];
            end
            sh = swh || (acc_store && srh);
        end
        if (!rst) begin
            chk(tag, "cfl_wr",  cfl_wr,  prb_valid && !prb_write && wh);
            chk(tag, "cfl_rw",  cfl_rw,  prb_valid &&  prb_write && rh);
            chk(tag, "cfl_ww",  cfl_ww,  prb_valid &&  prb_write && wh);
            chk(tag, "cfl_sum", cfl_sum, sh);
        end
        @(posedge clk);
        if (rst) begin
            m_rd = '{default:0}; m_wr = '{default:0};
            m_srd = '{default:0}; m_swr = '{default:0};
        end else begin
            if (clear) begin
                m_rd = '{default:0}; m_wr = '{default:0};
            end else if (ins) begin
                for (int j = 0; j < 2; j++) begin
                    if (acc_store) m_wr[j][hidx(acc_addr, j)] = 1;
                    else           m_rd[j][hidx(acc_addr, j)] = 1;
                end
            end
            if (sum_we) begin
                for (int i = 0; i < 32; i++) begin
                    if (sum_sel) m_swr[int'(sum_waddr)*32 + i] = sum_wdata[i];
                    else         m_srd[int'(sum_waddr)*32 + i] = sum_wdata[i];
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic probe(string tag, bit wr, logic [31:0] a);
        idle(); prb_valid = 1; prb_write = wr; prb_addr = a; step(tag);
    endtask

    task automatic access(string tag, bit st, bit tx, bit shd, logic [31:0] a);
        idle(); acc_valid = 1; acc_store = st; acc_tx = tx; acc_shared = shd;
        acc_addr = a; step(tag);
    endtask

    // set the summary bits of address a in both banks, one word at a time (R8)
    task automatic sum_mark(bit sel, logic [31:0] a);
        for (int j = 0; j < 2; j++) begin
            int f, w;
            logic [31:0] d;
            f = j*1024 + hidx(a, j);
            w = f / 32;
            for (int i = 0; i < 32; i++) d[i] = sel ? m_swr[w*32+i] : m_srd[w*32+i];
            d[f % 32] = 1'b1;
            idle(); sum_we = 1; sum_sel = sel; sum_waddr = 6'(w); sum_wdata = d;
            step("R8");
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a_ld, a_st, a_prv, a_ntx, a_cl, a_sg, a_sh;
        a_ld  = 32'h0012_3440;
        a_st  = 32'h0034_5680;
        a_prv = 32'h0056_78c0;
        a_ntx = 32'h0078_9a00;
        a_cl  = 32'h009a_bc40;
        a_sg  = 32'h00bc_de80;
        a_sh  = 32'h00de_f0c0;

        idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        step("R1"); step("R1");
        rst = 0;

        // R1: empty after reset
        idle(); prb_valid = 1; prb_write = 1; prb_addr = a_ld;
        acc_valid = 1; acc_store = 1; acc_addr = a_ld; step("R1");
        probe("R1", 0, a_st);

        // R5 / R4: load into read set, store into write set
        access("R5", 0, 1, 1, a_ld);
        probe("R4", 1, a_ld);
        probe("R4", 0, a_ld);
        access("R5", 1, 1, 1, a_st);
        probe("R4", 0, a_st);
        probe("R4", 1, a_st);
        idle(); prb_valid = 0; prb_addr = a_st; step("R4");

        // R5: private page and non-transactional references ignored
        access("R5", 1, 1, 0, a_prv);
        probe("R5", 0, a_prv);
        probe("R5", 1, a_prv);
        access("R5", 1, 0, 1, a_ntx);
        probe("R5", 0, a_ntx);

        // R2 / R3: offset and top bits ignored; a low field bit matters
        probe("R2", 0, a_st | 32'h0000_003f);
        probe("R3", 0, a_st ^ 32'hfc00_0000);
        probe("R2", 0, a_st ^ 32'h0000_0040);

        // R7: same-cycle insert and probe
        idle(); acc_valid = 1; acc_store = 1; acc_tx = 1; acc_shared = 1;
        acc_addr = 32'h0111_2200; prb_valid = 1; prb_write = 0;
        prb_addr = 32'h0111_2200; step("R7");
        idle(); acc_valid = 1; acc_tx = 1; acc_shared = 1;
        acc_addr = 32'h0222_3300; prb_valid = 1; prb_write = 1;
        prb_addr = 32'h0222_3300; step("R7");

        // R6: clear empties, drops same-cycle insert
        idle(); clear = 1; acc_valid = 1; acc_store = 1; acc_tx = 1;
        acc_shared = 1; acc_addr = a_cl; prb_valid = 1; prb_addr = a_cl; step("R6");
        probe("R6", 0, a_cl);
        probe("R6", 1, a_ld);
        probe("R6", 0, a_st);

        // R8 / R9: summary checks on local accesses
        sum_mark(1, a_sg);
        access("R9", 0, 0, 0, a_sg);
        access("R9", 1, 1, 1, a_sg);
        sum_mark(0, a_sh);
        access("R9", 0, 1, 1, a_sh);
        access("R9", 1, 0, 0, a_sh);
        access("R9", 0, 0, 0, a_ld);
        idle(); clear = 1; step("R6");
        access("R6", 0, 0, 0, a_sg);
        // R8: word overwrite with zero, same-cycle query sees old contents
        idle(); sum_we = 1; sum_sel = 1;
        sum_waddr = 6'(hidx(a_sg, 0) / 32); sum_wdata = '0;
        acc_valid = 1; acc_addr = a_sg; step("R8");
        access("R8", 0, 0, 0, a_sg);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ra, rp;
            idle();
            ra = {$urandom_range(63,0) == 0 ? 6'h3f : 6'h00, 6'h00,
                  4'($urandom_range(7,0)), 10'h000, 2'b00, 4'($urandom_range(15,0)),
                  6'($urandom)};
            rp = {6'($urandom), 6'h00, 4'($urandom_range(7,0)), 10'h000, 2'b00,
                  4'($urandom_range(15,0)), 6'($urandom)};
            if ($urandom_range(3,0) == 0) rp = ra;
            acc_valid  = $urandom_range(1,0) == 1;
            acc_store  = $urandom_range(1,0) == 1;
            acc_tx     = $urandom_range(3,0) != 0;
            acc_shared = $urandom_range(3,0) != 0;
            acc_addr   = ra;
            prb_valid  = $urandom_range(3,0) != 0;
            prb_write  = $urandom_range(1,0) == 1;
            prb_addr   = rp;
            clear      = $urandom_range(63,0) == 0;
            if ($urandom_range(15,0) == 0) begin
                sum_we    = 1;
                sum_sel   = $urandom_range(1,0) == 1;
                sum_waddr = 6'($urandom);
                sum_wdata = 32'h1 << $urandom_range(31,0);
            end
            step("R3");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule